// File: doc/BRIEF.md
# Pipelined Fixed-Point Reciprocal

This block takes a fixed-point scalar and returns its reciprocal in a second fixed-point format, one sample per clock. The quotient is built one bit at a time by a shift-and-subtract long division that is unrolled in space. The number of division steps comes from the two formats, and a latency strategy chosen at elaboration decides how many of those steps share one register stage. The input and the output use the same signedness. Negative inputs are handled by removing the sign before the division and restoring it after the last step.

A sample is offered by raising `in_vld` with the value on `in_x`. The matching result appears on `out_y` with `out_vld` high a fixed number of cycles later. There is no backpressure, so the block accepts a new sample on every cycle. Division by zero does not stall the pipeline: it gives a saturated result. Results that do not fit the output format are clamped.

Top module: `recip_pipe`

## Requirements
- R1: With S = |IN_FL + OUT_FL| and W = max(OUT_WL, IN_WL), the step count N is W+1 when S+1 = W, W when S+1 < W, S+2 when S ≥ W with signed formats, and S+1 when S ≥ W with unsigned formats.
- R2: In the maximum strategy (MODE = LAT_MAX), `out_vld` repeats `in_vld` exactly N+4 cycles later.
- R3: In the minimum strategy (LAT_MIN), the delay is 2 + ceil(N/3) cycles.
- R4: In the per-stage strategy (LAT_PER) with ITER_PER_STAGE = K, the delay is 2 + floor(N/K) cycles. For example, N=20 and K=5 give 6.
- R5: In the zero strategy (LAT_ZERO), the path is purely combinational and `out_vld` equals `in_vld` in the same cycle.
- R6: For a nonzero input X (two's complement when IS_SIGNED=1), the output integer is floor(2^S / |X|) carrying the sign of X. The magnitude is truncated, so rounding is toward zero.
- R7: A positive result above the largest output value is clamped to 2^(OUT_WL-1)-1 (signed) or 2^OUT_WL-1 (unsigned). A negative result below -2^(OUT_WL-1) is clamped to -2^(OUT_WL-1).
- R8: An input of zero yields the largest positive output value, and `out_vld` still asserts for it.
- R9: A synchronous `rst` clears the valid bit of every stage. After a reset edge, `out_vld` stays low until new valid samples arrive, and samples that were in flight are dropped.
- R10: Samples offered on consecutive cycles are each computed independently, with no bubbles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all stages register on the rising edge |
| rst | input | 1 | Synchronous reset; active high; clears stage valid bits |
| in_vld | input | 1 | Qualifies `in_x` in this cycle |
| in_x | input | IN_WL | Operand; IN_FL fraction bits; two's complement if IS_SIGNED |
| out_vld | output | 1 | Qualifies `out_y` |
| out_y | output | OUT_WL | Reciprocal; OUT_FL fraction bits; same signedness as input |

## Verification
On every cycle, the bound checker compares `out_vld` with a shadow copy of `in_vld` delayed by the configured latency. It also checks that a reset edge leaves `out_vld` low, that a zero operand comes out as the positive clamp value, and that the result sign in signed formats matches the operand sign. Only the bench scenarios can show that the step count and each latency formula resolve correctly for the four format and strategy combinations. The same applies to exact truncated quotients, clamping at both limits and at the negative boundary value, and to in-flight samples vanishing on a mid-stream reset.

// File: rtl/recip_pkg.sv
package recip_pkg;

   typedef enum logic [1:0] {
      LAT_MAX  = 2'd0,
      LAT_MIN  = 2'd1,
      LAT_PER  = 2'd2,
      LAT_ZERO = 2'd3
   } lat_mode_e;

   function automatic int frac_span(input int ifl, input int ofl);
      int s;
      s = ifl + ofl;
      return (s < 0) ? -s : s;
   endfunction

   // R1: number of quotient steps derived from both formats
   function automatic int step_count(input int iw, input int ifl, input int ow,
                                     input int ofl, input bit sg);
      int s;
      int w;
      s = frac_span(ifl, ofl);
      w = (ow >= iw) ? ow : iw;
      if (s < w) return (s + 1 == w) ? w + 1 : w;
      return sg ? s + 2 : s + 1;
   endfunction

   function automatic int group_size(input lat_mode_e m, input int k, input int n);
      case (m)
         LAT_MAX: return 1;
         LAT_MIN: return 3;
         LAT_PER: return k;
         default: return n + 1;
      endcase
   endfunction

   function automatic int edge_depth(input lat_mode_e m);
      case (m)
         LAT_MAX:  return 2;
         LAT_ZERO: return 0;
         default:  return 1;
      endcase
   endfunction

   function automatic bit reg_after(input lat_mode_e m, input int k, input int n, input int j);
      if (m == LAT_ZERO) return 1'b0;
      return ((j % k) == 0) || ((m == LAT_MIN) && (j == n));
   endfunction

   function automatic int stage_regs(input lat_mode_e m, input int k, input int n);
      int c;
      c = 0;
      for (int j = 1; j <= n; j++) if (reg_after(m, k, n, j)) c++;
      return c;
   endfunction

   function automatic int latency(input lat_mode_e m, input int n, input int k);
      case (m)
         LAT_MAX: return n + 4;
         LAT_MIN: return 2 + (n + 2) / 3;
         LAT_PER: return 2 + n / k;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/recip_dly.sv
module recip_dly #(
   parameter int W     = 8,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         vld_i,
   input  logic [W-1:0] dat_i,
   output logic         vld_o,
   output logic [W-1:0] dat_o
);
   if (DEPTH == 0) begin : g_thru
      assign vld_o = vld_i;
      assign dat_o = dat_i;
   end else begin : g_pipe
      logic [DEPTH-1:0] v_sr;
      logic [W-1:0]     d_sr [DEPTH];

      always_ff @(posedge clk) begin
         if (rst) v_sr <= '0;
         else begin
            v_sr[0] <= vld_i;
            for (int i = 1; i < DEPTH; i++) v_sr[i] <= v_sr[i-1];
         end
         d_sr[0] <= dat_i;
         for (int i = 1; i < DEPTH; i++) d_sr[i] <= d_sr[i-1];
      end

      assign vld_o = v_sr[DEPTH-1];
      assign dat_o = d_sr[DEPTH-1];
   end
endmodule

// File: rtl/recip_step.sv
module recip_step #(
   parameter int MW   = 8,
   parameter int QW   = 8,
   parameter int QBIT = 0,
   parameter bit DBIT = 1'b0
) (
   input  logic [MW-1:0] mag,
   input  logic [MW-1:0] rem_i,
   input  logic [QW-1:0] quo_i,
   output logic [MW-1:0] rem_o,
   output logic [QW-1:0] quo_o
);
   logic [MW:0] trial;
   logic        take;

   assign trial = {rem_i, DBIT};
   assign take  = trial >= {1'b0, mag};
   assign rem_o = take ? MW'(trial - {1'b0, mag}) : trial[MW-1:0];

   always_comb begin
      quo_o       = quo_i;
      quo_o[QBIT] = take;
   end
endmodule

// File: rtl/recip_sat.sv
module recip_sat #(
   parameter int QW = 10,
   parameter int OW = 8,
   parameter bit SG = 1'b1
) (
   input  logic          neg,
   input  logic [QW-1:0] quo,
   output logic [OW-1:0] res
);
   localparam logic [QW-1:0] LIM_P = QW'((64'd1 << (SG ? OW - 1 : OW)) - 64'd1);
   localparam logic [QW-1:0] LIM_N = QW'(64'd1 << (OW - 1));

   logic [QW-1:0] sel;

   always_comb begin
      if (neg) sel = (quo > LIM_N) ? LIM_N : quo;
      else     sel = (quo > LIM_P) ? LIM_P : quo;
      res = neg ? OW'(~sel + 1'b1) : OW'(sel);
   end
endmodule

// File: rtl/recip_pipe.sv
module recip_pipe
   import recip_pkg::*;
#(
   parameter int        IN_WL          = 8,
   parameter int        IN_FL          = 4,
   parameter int        OUT_WL         = 10,
   parameter int        OUT_FL         = 4,
   parameter bit        IS_SIGNED      = 1'b1,
   parameter lat_mode_e MODE           = LAT_MAX,
   parameter int        ITER_PER_STAGE = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_vld,
   input  logic [IN_WL-1:0]  in_x,
   output logic              out_vld,
   output logic [OUT_WL-1:0] out_y
);
   localparam int S    = frac_span(IN_FL, OUT_FL);
   localparam int N    = step_count(IN_WL, IN_FL, OUT_WL, OUT_FL, IS_SIGNED);
   localparam int K    = group_size(MODE, ITER_PER_STAGE, N);
   localparam int EDGE = edge_depth(MODE);
   localparam int LAT  = latency(MODE, N, ITER_PER_STAGE);

   if (IN_WL < 2 || OUT_WL < 2) begin : g_bad_width
      $error("recip_pipe: word lengths must be at least 2");
   end
   if (ITER_PER_STAGE < 1) begin : g_bad_k
      $error("recip_pipe: ITER_PER_STAGE must be positive");
   end
   if (IN_FL + OUT_FL < 0) begin : g_bad_frac
      $error("recip_pipe: fraction lengths must not sum below zero");
   end
   if (N > 62) begin : g_bad_n
      $error("recip_pipe: step count too large");
   end
   if (2 * EDGE + stage_regs(MODE, K, N) != LAT) begin : g_bad_lat
      $error("recip_pipe: register placement disagrees with latency formula");
   end

   // entry delay
   logic             pv;
   logic [IN_WL-1:0] px;

   recip_dly #(.W(IN_WL), .DEPTH(EDGE)) u_pre (
      .clk(clk), .rst(rst), .vld_i(in_vld), .dat_i(in_x),
      .vld_o(pv), .dat_o(px)
   );

   // sign removal
   logic             neg0;
   logic [IN_WL-1:0] mag0;
   assign neg0 = IS_SIGNED && px[IN_WL-1];
   assign mag0 = neg0 ? (~px + 1'b1) : px;

   logic             st_v [0:N];
   logic             st_n [0:N];
   logic [IN_WL-1:0] st_m [0:N];
   logic [IN_WL-1:0] st_r [0:N];
   logic [N-1:0]     st_q [0:N];

   assign st_v[0] = pv;
   assign st_n[0] = neg0;
   assign st_m[0] = mag0;
   assign st_r[0] = '0;
   assign st_q[0] = '0;

   for (genvar j = 1; j <= N; j++) begin : g_it
      logic [IN_WL-1:0] r_nx;
      logic [N-1:0]     q_nx;
      logic             v_o;
      logic             n_o;
      logic [IN_WL-1:0] m_o;
      logic [IN_WL-1:0] r_o;
      logic [N-1:0]     q_o;

      recip_step #(
         .MW(IN_WL), .QW(N), .QBIT(N - j), .DBIT((N - j) == S)
      ) u_step (
         .mag(st_m[j-1]), .rem_i(st_r[j-1]), .quo_i(st_q[j-1]),
         .rem_o(r_nx), .quo_o(q_nx)
      );

      if (reg_after(MODE, K, N, j)) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst) v_o <= 1'b0;
            else     v_o <= st_v[j-1];
            n_o <= st_n[j-1];
            m_o <= st_m[j-1];
            r_o <= r_nx;
            q_o <= q_nx;
         end
      end else begin : g_wire
         assign v_o = st_v[j-1];
         assign n_o = st_n[j-1];
         assign m_o = st_m[j-1];
         assign r_o = r_nx;
         assign q_o = q_nx;
      end

      assign st_v[j] = v_o;
      assign st_n[j] = n_o;
      assign st_m[j] = m_o;
      assign st_r[j] = r_o;
      assign st_q[j] = q_o;
   end

   // sign restore and clamp
   logic [OUT_WL-1:0] y_raw;

   recip_sat #(.QW(N), .OW(OUT_WL), .SG(IS_SIGNED)) u_sat (
      .neg(st_n[N]), .quo(st_q[N]), .res(y_raw)
   );

   recip_dly #(.W(OUT_WL), .DEPTH(EDGE)) u_post (
      .clk(clk), .rst(rst), .vld_i(st_v[N]), .dat_i(y_raw),
      .vld_o(out_vld), .dat_o(out_y)
   );
endmodule

// File: rtl/recip_pipe_chk.sv
module recip_pipe_chk #(
   parameter int IW  = 8,
   parameter int OW  = 10,
   parameter bit SG  = 1'b1,
   parameter int LAT = 14
) (
   input logic          clk,
   input logic          rst,
   input logic          in_vld,
   input logic [IW-1:0] in_x,
   input logic          out_vld,
   input logic [OW-1:0] out_y
);
   localparam logic [OW-1:0] Y_TOP = OW'((64'd1 << (SG ? OW - 1 : OW)) - 64'd1);

   if (LAT == 0) begin : g_comb
      // R5: combinational valid path
      assert_comb_valid_R5: assert property (@(posedge clk) out_vld == in_vld);

      // R8: zero operand clamps to the positive limit
      assert_zero_sat_R8: assert property (@(posedge clk)
         (in_vld && in_x == '0) |-> out_y == Y_TOP);

      if (SG) begin : g_sign
         // R6: result sign follows the operand sign
         assert_sign_R6: assert property (@(posedge clk)
            in_vld |-> (in_x[IW-1] ? (out_y[OW-1] || out_y == '0) : !out_y[OW-1]));
      end
   end else begin : g_seq
      logic [LAT-1:0] sh_v;
      logic [LAT-1:0] sh_z;
      logic [LAT-1:0] sh_n;
      logic           armed;

      always_ff @(posedge clk) begin
         if (rst) begin
            sh_v  <= '0;
            armed <= 1'b1;
         end else begin
            sh_v[0] <= in_vld;
            for (int i = 1; i < LAT; i++) sh_v[i] <= sh_v[i-1];
         end
         sh_z[0] <= (in_x == '0);
         sh_n[0] <= SG && in_x[IW-1];
         for (int i = 1; i < LAT; i++) begin
            sh_z[i] <= sh_z[i-1];
            sh_n[i] <= sh_n[i-1];
         end
      end

      // R2 (also R3, R4): valid emerges exactly LAT cycles after entry
      assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
         armed |-> out_vld == sh_v[LAT-1]);

      // R9: a reset edge leaves the output valid low
      assert_reset_clear_R9: assert property (@(posedge clk) rst |=> !out_vld);

      // R8: zero operand clamps to the positive limit
      assert_zero_sat_R8: assert property (@(posedge clk) disable iff (rst)
         (armed && out_vld && sh_z[LAT-1]) |-> out_y == Y_TOP);

      if (SG) begin : g_sign
         // R6: result sign follows the operand sign
         assert_sign_R6: assert property (@(posedge clk) disable iff (rst)
            (armed && out_vld) |->
               (sh_n[LAT-1] ? (out_y[OW-1] || out_y == '0) : !out_y[OW-1]));
      end
   end
endmodule

bind recip_pipe recip_pipe_chk #(
   .IW(IN_WL), .OW(OUT_WL), .SG(IS_SIGNED), .LAT(LAT)
) u_chk (
   .clk(clk), .rst(rst), .in_vld(in_vld), .in_x(in_x),
   .out_vld(out_vld), .out_y(out_y)
);

// File: tb/sim_recip_pipe.sv
module sim_recip_pipe;
   import recip_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int ND = 4;
   localparam int C_IW [ND] = '{8, 10, 16, 6};
   localparam int C_IF [ND] = '{4, 4, 3, 3};
   localparam int C_OW [ND] = '{10, 8, 16, 6};
   localparam int C_OF [ND] = '{4, 5, 16, 3};
   localparam bit C_SG [ND] = '{1'b1, 1'b1, 1'b0, 1'b1};
   localparam int C_MD [ND] = '{0, 1, 2, 3};   // max, min, per-stage, zero
   localparam int C_K  [ND] = '{1, 1, 5, 1};

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_vld = 1'b0;
   logic [31:0] raw = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   logic        ov [ND];
   logic [31:0] oy [ND];
   logic [9:0]  y0;
   logic [7:0]  y1;
   logic [15:0] y2;
   logic [5:0]  y3;

   recip_pipe #(.IN_WL(8), .IN_FL(4), .OUT_WL(10), .OUT_FL(4), .IS_SIGNED(1'b1),
                .MODE(LAT_MAX), .ITER_PER_STAGE(1)) u0 (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_x(raw[7:0]), .out_vld(ov[0]), .out_y(y0));
   recip_pipe #(.IN_WL(10), .IN_FL(4), .OUT_WL(8), .OUT_FL(5), .IS_SIGNED(1'b1),
                .MODE(LAT_MIN), .ITER_PER_STAGE(1)) u1 (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_x(raw[9:0]), .out_vld(ov[1]), .out_y(y1));
   recip_pipe #(.IN_WL(16), .IN_FL(3), .OUT_WL(16), .OUT_FL(16), .IS_SIGNED(1'b0),
                .MODE(LAT_PER), .ITER_PER_STAGE(5)) u2 (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_x(raw[15:0]), .out_vld(ov[2]), .out_y(y2));
   recip_pipe #(.IN_WL(6), .IN_FL(3), .OUT_WL(6), .OUT_FL(3), .IS_SIGNED(1'b1),
                .MODE(LAT_ZERO), .ITER_PER_STAGE(1)) u3 (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_x(raw[5:0]), .out_vld(ov[3]), .out_y(y3));

   assign oy[0] = 32'(y0);
   assign oy[1] = 32'(y1);
   assign oy[2] = 32'(y2);
   assign oy[3] = 32'(y3);

   int          n_chk = 0;
   int          n_bad = 0;
   int          lat [ND];
   string       phase = "";
   logic [36:0] q [ND][$];

   // R1: step count from the formats
   function automatic int iters(input int d);
      int s, w;
      s = C_IF[d] + C_OF[d];
      if (s < 0) s = -s;
      w = (C_OW[d] > C_IW[d]) ? C_OW[d] : C_IW[d];
      if (s >= w) return C_SG[d] ? s + 2 : s + 1;
      if (s + 1 == w) return w + 1;
      return w;
   endfunction

   function automatic int lat_calc(input int d);
      int n;
      n = iters(d);
      case (C_MD[d])
         0: return n + 4;                                  // R2
         1: return 2 + (n / 3) + ((n % 3 != 0) ? 1 : 0);   // R3
         2: return 2 + n / C_K[d];                         // R4
         default: return 0;                                // R5
      endcase
   endfunction

   function automatic string lat_tag(input int d);
      case (d)
         0: return "R1 R2";
         1: return "R1 R3";
         2: return "R1 R4";
         default: return "R1 R5";
      endcase
   endfunction

   function automatic string val_tag(input logic [3:0] c);
      case (c)
         4'd7:    return "R7";
         4'd8:    return "R8";
         default: return "R6";
      endcase
   endfunction

   function automatic logic [31:0] expect_y(input int d, input logic [31:0] x,
                                            output logic [3:0] code);
      longint iw, ow, s, xv, mag, qv, maxp, maxn, r;
      bit     neg;
      iw = C_IW[d];
      ow = C_OW[d];
      s  = C_IF[d] + C_OF[d];
      if (s < 0) s = -s;
      xv = longint'({32'd0, x}) & ((64'sd1 <<< iw) - 1);
      if (C_SG[d] && xv[iw-1]) xv = xv - (64'sd1 <<< iw);
      neg  = xv < 0;
      mag  = neg ? -xv : xv;
      maxp = C_SG[d] ? (64'sd1 <<< (ow - 1)) - 1 : (64'sd1 <<< ow) - 1;
      maxn = 64'sd1 <<< (ow - 1);
      if (mag == 0) begin
         code = 4'd8;
         r = maxp;
      end else begin
         qv = (64'sd1 <<< s) / mag;
         if (neg) begin
            if (qv > maxn) begin code = 4'd7; r = -maxn; end
            else begin code = 4'd6; r = -qv; end
         end else begin
            if (qv > maxp) begin code = 4'd7; r = maxp; end
            else begin code = 4'd6; r = qv; end
         end
      end
      return 32'(r & ((64'sd1 <<< ow) - 1));
   endfunction

   task automatic fail_line(input string tag, input int d, input logic [31:0] act,
                            input logic [31:0] exp);
      n_bad++;
      $display("FAIL %s %s u%0d actual=%0h expected=%0h at %0t", tag, phase, d, act, exp, $time);
   endtask

   // One cycle: drive at the falling edge, then compare every output with the
   // reference entry that is exactly its latency old.
   task automatic tick(input bit v, input logic [31:0] x, input bit r);
      logic [3:0]  code;
      logic [31:0] ye;
      logic [36:0] e;
      @(negedge clk);
      rst    = r;
      in_vld = v && !r;
      raw    = x;
      for (int d = 0; d < ND; d++) begin
         ye = expect_y(d, x, code);
         q[d].push_front({in_vld, code, ye});
      end
      #1;
      for (int d = 0; d < ND; d++) begin
         e = q[d][lat[d]];
         n_chk++;
         if (ov[d] !== e[36]) fail_line(lat_tag(d), d, 32'(ov[d]), 32'(e[36]));
         else if (e[36] && oy[d] !== e[31:0]) fail_line(val_tag(e[35:32]), d, oy[d], e[31:0]);
      end
      if (r) begin
         for (int d = 0; d < ND; d++)
            for (int i = 0; i < q[d].size(); i++) begin
               e = q[d][i];
               e[36] = 1'b0;
               q[d][i] = e;
            end
      end
      for (int d = 0; d < ND; d++)
         while (q[d].size() > lat[d] + 1) void'(q[d].pop_back());
   endtask

   localparam int NCORN = 19;
   localparam logic [31:0] CORN [NCORN] = '{
      32'h0, 32'h1, 32'h2, 32'h3, 32'h4, 32'h5, 32'h7, 32'h8,
      32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'hFFFF_FFFC, 32'h20, 32'h80,
      32'h200, 32'h8000, 32'h7F, 32'h1F, 32'h1FF, 32'h7FFF};

   initial begin
      for (int d = 0; d < ND; d++) begin
         lat[d] = lat_calc(d);
         for (int i = 0; i <= lat[d]; i++) q[d].push_front(37'd0);
      end
      // R9: reset state
      for (int i = 0; i < 4; i++) tick(1'b1, 32'h1, 1'b1);
      phase = "R9";
      for (int d = 0; d < ND; d++) begin
         n_chk++;
         if (ov[d] !== 1'b0) fail_line("R9", d, 32'(ov[d]), 32'd0);
      end
      phase = "";
      tick(1'b0, 32'h0, 1'b0);
      // corner operands, isolated and then back to back
      for (int i = 0; i < NCORN; i++) begin
         tick(1'b1, CORN[i], 1'b0);
         tick(1'b0, 32'h0, 1'b0);
      end
      phase = "R10";
      for (int i = 0; i < NCORN; i++) tick(1'b1, CORN[i], 1'b0);
      // random operands with gaps
      phase = "";
      for (int i = 0; i < 2000; i++) tick(($urandom % 4) != 0, $urandom, 1'b0);
      // continuous stream
      phase = "R10";
      for (int i = 0; i < 300; i++) tick(1'b1, $urandom, 1'b0);
      // reset while samples are in flight
      phase = "R9";
      tick(1'b1, 32'h0, 1'b1);
      tick(1'b1, 32'h3, 1'b1);
      for (int i = 0; i < 40; i++) tick(1'b0, 32'h0, 1'b0);
      for (int i = 0; i < 10; i++) tick(1'b1, $urandom, 1'b0);
      tick(1'b1, 32'h5, 1'b1);
      for (int i = 0; i < 40; i++) tick(($urandom % 2) != 0, $urandom, 1'b0);
      phase = "";
      for (int i = 0; i < 30; i++) tick(1'b0, 32'h0, 1'b0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R10 actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule